// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block holds the 32-bit interrupt control and status word of a seven-channel DMA engine. A bus write sets the force bit, the per-channel interrupt enables and the master enable in one step. The same write clears per-channel flags: a one in a flag position clears that flag, and a zero leaves it alone. A completion strobe with a channel index sets that channel's flag, but only when the channel's enable is set.

From these fields the block derives a read-only master flag. The master flag is set when the force bit is set. It is also set when the master enable is on and at least one flag is set whose channel is enabled. Each rising edge of the master flag produces a single-cycle interrupt request pulse for the downstream interrupt controller. The read port returns the whole word at all times.

Field layout in the word: bit 15 force, bits 22:16 channel enables (channel n at 16+n), bit 23 master enable, bits 30:24 channel flags (channel n at 24+n), bit 31 master flag. Bits 14:0 always read as zero.

Top module: `dma_irq_status`

## Requirements
- R1: A synchronous active-high reset clears the whole word to zero, and `irq_pulse` is low while reset is held.
- R2: A write loads bit 15 (force), bits 22:16 (enables) and bit 23 (master enable) from `wr_data`. The written values of bits 14:0 and bit 31 are ignored, and bits 14:0 always read as zero.
- R3: A completion on channel n (0..6) sets flag bit 24+n only if enable bit 16+n is set in the value held before that clock edge. A completion with index 7 changes nothing.
- R4: A write with a one in bit 24+n clears flag n. A zero in that position leaves the flag unchanged.
- R5: When a completion and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Bit 31 reads as force OR (master enable AND any flag whose enable is set). It reflects the new field values from the cycle after the write or completion edge.
- R7: `irq_pulse` is high for exactly one cycle, in the cycle in which bit 31 first reads 1 after having read 0. It stays low while bit 31 stays 1 and when bit 31 falls.
- R8: The master flag is re-evaluated after every write as well as after every completion. A write that clears the last enabled flag drops bit 31, and a later rise of bit 31 gives a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data (control fields, flag clear mask) |
| done_valid | input | 1 | Transfer completion strobe |
| done_chan | input | 3 | Channel index of the completion |
| rd_data | output | 32 | Full register read value |
| irq_pulse | output | 1 | Single-cycle interrupt request |

## Verification
A write or a completion presented before clock edge k shows up in `rd_data` right after edge k. The pulse that belongs to that change is also high from edge k until edge k+1, because both outputs come combinationally from registers updated at k. The driver applies each stimulus at a falling edge and pushes its expected word and pulse after the following rising edge. The monitor pops and compares them at the next falling edge, so each check lands one cycle after its stimulus. A second entry with the pulse expected low checks that the pulse has ended.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int NUM_CH    = 7;
    localparam int REG_W     = 32;
    localparam int CH_W      = $clog2(NUM_CH + 1);
    localparam int FORCE_BIT = 15;
    localparam int ENA_LSB   = FORCE_BIT + 1;
    localparam int MEN_BIT   = ENA_LSB + NUM_CH;
    localparam int FLAG_LSB  = MEN_BIT + 1;
    localparam int MFLAG_BIT = FLAG_LSB + NUM_CH;

    typedef logic [NUM_CH-1:0] ch_vec_t;

    typedef struct packed {
        logic    force_irq;
        ch_vec_t ena;
        logic    master_en;
    } irq_ctrl_t;

    function automatic logic master_eq(irq_ctrl_t c, ch_vec_t flags);
        return c.force_irq | (c.master_en & (|(c.ena & flags)));
    endfunction

    function automatic logic [REG_W-1:0] pack_word(irq_ctrl_t c, ch_vec_t flags, logic mflag);
        logic [REG_W-1:0] w;
        w                      = '0;
        w[FORCE_BIT]           = c.force_irq;
        w[ENA_LSB +: NUM_CH]   = c.ena;
        w[MEN_BIT]             = c.master_en;
        w[FLAG_LSB +: NUM_CH]  = flags;
        w[MFLAG_BIT]           = mflag;
        return w;
    endfunction

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dma_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  irq_ctrl_t wr_ctrl,
    output irq_ctrl_t ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_ctrl;
        end
    end

    // R2: a write lands in the control fields one edge later
    p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl_q == $past(wr_ctrl)));

    // R2: without a write the control fields hold
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
    import dma_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            done_valid,
    input  logic [CH_W-1:0] done_chan,
    input  ch_vec_t         ena,
    input  logic            clr_en,
    input  ch_vec_t         clr_mask,
    output ch_vec_t         flags_q
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic set_c;
        logic clr_c;

        assign set_c = done_valid && (done_chan == CH_W'(g)) && ena[g];
        assign clr_c = clr_en && clr_mask[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[g] <= 1'b0;
            end else if (set_c) begin
                flags_q[g] <= 1'b1;     // completion has priority (R5)
            end else if (clr_c) begin
                flags_q[g] <= 1'b0;
            end
        end

        // R3 / R5: an enabled completion always leaves the flag set
        p_set_r3: assert property (@(posedge clk) disable iff (rst)
            (done_valid && (done_chan == CH_W'(g)) && ena[g]) |=> flags_q[g]);

        // R4: a clear with no competing completion empties the flag
        p_clear_r4: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_mask[g] && !(done_valid && (done_chan == CH_W'(g))))
            |=> !flags_q[g]);

        // R3: a disabled channel's flag never rises without a write
        p_no_set_disabled_r3: assert property (@(posedge clk) disable iff (rst)
            (!ena[g] && !clr_en) |=> $stable(flags_q[g]));
    end

endmodule

// File: rtl/dma_irq_edge.sv
module dma_irq_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    assign pulse = level & ~level_q;

    // R7: the request never lasts two cycles
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             done_valid,
    input  logic [CH_W-1:0]  done_chan,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_pulse
);

    irq_ctrl_t wr_ctrl;
    irq_ctrl_t ctrl_q;
    ch_vec_t   flags_q;
    logic      master;
    logic      unused_wr_bits;

    assign wr_ctrl.force_irq = wr_data[FORCE_BIT];
    assign wr_ctrl.ena       = wr_data[ENA_LSB +: NUM_CH];
    assign wr_ctrl.master_en = wr_data[MEN_BIT];
    assign unused_wr_bits    = ^{wr_data[FORCE_BIT-1:0], wr_data[MFLAG_BIT]};

    dma_irq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ctrl (wr_ctrl),
        .ctrl_q  (ctrl_q)
    );

    dma_irq_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .done_valid (done_valid),
        .done_chan  (done_chan),
        .ena        (ctrl_q.ena),
        .clr_en     (wr_en),
        .clr_mask   (wr_data[FLAG_LSB +: NUM_CH]),
        .flags_q    (flags_q)
    );

    assign master  = master_eq(ctrl_q, flags_q);
    assign rd_data = pack_word(ctrl_q, flags_q, master);

    dma_irq_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (master),
        .pulse (irq_pulse)
    );

    // R7: a pulse only appears while the master flag reads 1
    p_pulse_needs_master_r7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> rd_data[MFLAG_BIT]);

    // R7: a master flag that was already high gives no pulse
    p_no_pulse_when_held_r7: assert property (@(posedge clk) disable iff (rst)
        rd_data[MFLAG_BIT] |=> (rd_data[MFLAG_BIT] -> !irq_pulse));

    // R6: the force bit alone drives the master flag
    p_force_master_r6: assert property (@(posedge clk) disable iff (rst)
        rd_data[FORCE_BIT] |-> rd_data[MFLAG_BIT]);

    // R2: the low bits never read back anything but zero
    p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[FORCE_BIT-1:0] == '0);

endmodule

// File: tb/dma_irq_status_test.sv
module dma_irq_status_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        done_valid;
    logic [2:0]  done_chan;
    logic [31:0] rd_data;
    logic        irq_pulse;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] word;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // reference state, derived from the requirements
    logic       m_force;
    logic [6:0] m_ena;
    logic       m_men;
    logic [6:0] m_flags;
    logic       m_prev;

    always #(CLK_P/2) clk = ~clk;

    dma_irq_status uut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .done_valid (done_valid),
        .done_chan  (done_chan),
        .rd_data    (rd_data),
        .irq_pulse  (irq_pulse)
    );

    function automatic logic [31:0] model_word();
        logic m;
        m = m_force | (m_men & (|(m_ena & m_flags)));
        return {m, m_flags, m_men, m_ena, m_force, 15'd0};
    endfunction

    task automatic step(input logic w, input logic [31:0] d,
                        input logic dv, input logic [2:0] ch, input string tag);
        logic [6:0]  setv;
        logic [6:0]  clrv;
        logic [31:0] wexp;
        exp_t        e;
        @(negedge clk);
        wr_en      = w;
        wr_data    = d;
        done_valid = dv;
        done_chan  = ch;
        setv = '0;
        if (dv && ch < 3'd7 && m_ena[ch]) setv[ch] = 1'b1;   // enable held before the edge
        clrv = w ? d[30:24] : 7'd0;
        m_flags = (m_flags & ~clrv) | setv;
        if (w) begin
            m_force = d[15];
            m_ena   = d[22:16];
            m_men   = d[23];
        end
        @(posedge clk);
        #1;
        wexp   = model_word();
        e.word = wexp;
        e.irq  = wexp[31] & ~m_prev;
        e.tag  = tag;
        m_prev = wexp[31];
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 32'd0, 1'b0, 3'd0, tag);
    endtask

    // monitor: compares one due result per falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (rd_data !== e.word || irq_pulse !== e.irq) begin
                errors++;
                $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                         e.tag, rd_data, irq_pulse, e.word, e.irq);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [31:0] EN02 = (32'd1 << 16) | (32'd1 << 18) | (32'd1 << 23);

    initial begin
        m_force = 0; m_ena = '0; m_men = 0; m_flags = '0; m_prev = 0;
        rst = 1'b1; wr_en = 0; wr_data = '0; done_valid = 0; done_chan = '0;
        repeat (3) @(posedge clk);
        // R1: reset clears everything, even with inputs active during reset
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'hFFFF_FFFF; done_valid = 1'b1; done_chan = 3'd0;
        @(negedge clk);
        checks++;
        if (rd_data !== 32'd0 || irq_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     rd_data, irq_pulse, 32'd0, 1'b0);
        end
        wr_en = 0; wr_data = '0; done_valid = 0;
        rst = 1'b0;
        idle("R1 after release");

        step(1'b1, 32'h8000_7FFF | EN02, 1'b0, 3'd0, "R2 write with ignored bits");
        step(1'b0, 32'd0, 1'b1, 3'd1, "R3 disabled channel 1");
        step(1'b0, 32'd0, 1'b1, 3'd0, "R3 R6 R7 channel 0 raises master");
        idle("R7 pulse ends");
        step(1'b0, 32'd0, 1'b1, 3'd2, "R7 no pulse while held");
        step(1'b1, EN02 | (32'd1 << 24), 1'b0, 3'd0, "R4 clear flag 0 keeps flag 2");
        step(1'b1, EN02, 1'b0, 3'd0, "R4 zero mask keeps flag 2");
        step(1'b1, EN02 | (32'd1 << 26), 1'b0, 3'd0, "R8 clear last flag drops master");
        step(1'b0, 32'd0, 1'b1, 3'd0, "R8 new rise gives new pulse");
        step(1'b1, EN02 | (32'd1 << 26) | (32'd1 << 24), 1'b1, 3'd2, "R5 completion beats clear");
        step(1'b0, 32'd0, 1'b1, 3'd7, "R3 index 7 ignored");
        step(1'b1, (32'd1 << 16) | (32'd1 << 18), 1'b0, 3'd0, "R6 master enable off drops master");
        step(1'b1, 32'd1 << 15, 1'b0, 3'd0, "R6 R7 force raises master");
        step(1'b1, 32'd1 << 15, 1'b0, 3'd0, "R7 force held no pulse");
        step(1'b1, 32'h7F00_0000, 1'b0, 3'd0, "R4 R6 clear all flags and force");
        step(1'b1, (32'd1 << 23) | (32'd1 << 17), 1'b1, 3'd1, "R3 enable written same edge not used");
        step(1'b0, 32'd0, 1'b1, 3'd1, "R3 R6 R7 channel 1 now enabled");
        idle("R7 pulse ends again");
        idle("R6 master stays");

        wait (sb.size() == 0);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule